// File: doc/BRIEF.md
# Ten-Channel DMA Request Arbiter

This block decides which of ten DMA channels carries out the next single transfer. Every channel picks one request source. It can be a one-cycle software trigger, the rising edge of a peripheral request line, or a cascade event caused by another channel's progress. A request event that reaches an enabled channel raises that channel's pending flag.

When no transfer is in flight, the arbiter grants the pending channel with the lowest index. It holds that one-hot grant until the channel's engine reports the transfer done, then drops the grant and arbitrates again. In this way the bus is handed back after each individual transfer.

The cascade network is fixed and irregular. Most links fire when the source channel finishes one transfer. One extra link fires when channel 0 reports that its transfer count has underflowed. The per-channel engines do the addressing, the data movement and the counting. They report back only through their done and underflow pulses.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, grant is all zero, busy is low and no channel is pending.
- R2: Each channel's 2-bit source field (bits 2c+1:2c of the select bus) chooses its request: 0 is the software trigger pulse, 1 is the rising edge of its peripheral line, 2 is a cascade event, and 3 is no source.
- R3: A channel whose enable bit is low ignores every request, including cascade events. Its pending flag is cleared at the next clock edge, so it is not granted while it stays disabled.
- R4: Priority is fixed, with the lowest index winning. A request event in cycle t sets the pending flag at the following edge. An idle arbiter then grants the lowest pending channel one edge later.
- R5: At most one grant bit is high at any time. The grant stays unchanged until the granted channel pulses its done input. Done and underflow pulses from channels that are not granted have no effect.
- R6: A done pulse from the granted channel clears that channel's pending flag and drops the grant for one cycle. Arbitration resumes on the next edge.
- R7: A done pulse from the granted channel is a cascade event for the targets listed here: 0 to 1, 1 to 2, 2 to 0, 2 to 3, 3 to 4, 5 to 6, 6 to 7, 7 to 5, 7 to 8, and 8 to 9.
- R8: An underflow pulse from channel 0 while channel 0 is granted is a cascade event for channel 5.
- R9: A request that arrives while the channel is already pending merges into the existing flag and does not cause a second grant. A request that arrives in the same cycle as the channel's own done leaves the channel pending.
- R10: The busy output is high exactly when some grant bit is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanEnable | input | 10 | Per-channel enable |
| srcSel | input | 20 | Per-channel 2-bit request source select |
| swTrig | input | 10 | Per-channel software trigger pulse |
| periphReq | input | 10 | Per-channel peripheral request line, edge sensitive |
| xferDone | input | 10 | Per-channel single-transfer-done pulse from the engines |
| cntUnderflow | input | 10 | Per-channel transfer-count underflow pulse from the engines |
| grant | output | 10 | One-hot grant for the channel doing the current transfer |
| busy | output | 1 | A transfer is granted and in flight |

## Verification
A pending flag that is lost, duplicated or left stale shows up at the ports within two edges. The grant skips a channel, grants it a second time, or serves it after it was disabled, and the reference model catches each of these on the very cycle the grant changes. A wrong cascade wire or a missing underflow link shows the same way: the target channel's grant is absent, or it appears when it should not, two edges after the source's done pulse. A grant register that fails to hold or to release shows up one cycle after the done pulse, as a mismatch on grant and busy.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NUM_CH = 10;
  localparam int SEL_W = 2;
  localparam int UFLOW_SRC = 0;
  localparam int UFLOW_DST = 5;

  typedef enum logic [SEL_W-1:0] {
    SRC_SOFT    = 2'd0,
    SRC_PERIPH  = 2'd1,
    SRC_CASCADE = 2'd2,
    SRC_OFF     = 2'd3
  } reqSrc_e;

  // Strobes from the grant control to the pending datapath.
  typedef struct packed {
    logic [NUM_CH-1:0] completeMask;
    logic [NUM_CH-1:0] underflowMask;
  } arbStrobes_t;

  // Channels whose single-transfer completion triggers the given target.
  function automatic logic [NUM_CH-1:0] cascadeSources(input int target);
    logic [NUM_CH-1:0] srcMask;
    srcMask = '0;
    case (target)
      0: srcMask[2] = 1'b1;
      1: srcMask[0] = 1'b1;
      2: srcMask[1] = 1'b1;
      3: srcMask[2] = 1'b1;
      4: srcMask[3] = 1'b1;
      5: srcMask[7] = 1'b1;
      6: srcMask[5] = 1'b1;
      7: srcMask[6] = 1'b1;
      8: srcMask[7] = 1'b1;
      9: srcMask[8] = 1'b1;
      default: srcMask = '0;
    endcase
    return srcMask;
  endfunction
endpackage

// File: rtl/dmaArbPendPath.sv
module dmaArbPendPath
  import dma_arb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       chanEnable,
  input  logic [NUM_CH*SEL_W-1:0] srcSel,
  input  logic [NUM_CH-1:0]       swTrig,
  input  logic [NUM_CH-1:0]       periphReq,
  input  arbStrobes_t             strobes,
  output logic [NUM_CH-1:0]       pendQ
);
  logic [NUM_CH-1:0] periphPrevQ;
  logic [NUM_CH-1:0] reqEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) periphPrevQ <= '0;
    else       periphPrevQ <= periphReq;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    reqSrc_e chSel;
    logic    cascadeHit;
    logic    chEvent;

    assign chSel = reqSrc_e'(srcSel[ch*SEL_W +: SEL_W]);

    if (ch == UFLOW_DST) begin : gUflowTarget
      assign cascadeHit = (|(strobes.completeMask & cascadeSources(ch)))
                          | strobes.underflowMask[UFLOW_SRC];
    end else begin : gPlainTarget
      assign cascadeHit = |(strobes.completeMask & cascadeSources(ch));
    end

    always_comb begin
      unique case (chSel)
        SRC_SOFT:    chEvent = swTrig[ch];
        SRC_PERIPH:  chEvent = periphReq[ch] & ~periphPrevQ[ch];
        SRC_CASCADE: chEvent = cascadeHit;
        default:     chEvent = 1'b0;
      endcase
    end

    assign reqEvent[ch] = chEvent;
  end

  // A new event wins over the completion clear; disabled channels drop their flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= chanEnable & (reqEvent | (pendQ & ~strobes.completeMask));
  end
endmodule

// File: rtl/dmaArbGrantCtl.sv
module dmaArbGrantCtl
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pendQ,
  input  logic [NUM_CH-1:0] xferDone,
  input  logic [NUM_CH-1:0] cntUnderflow,
  output logic [NUM_CH-1:0] grantQ,
  output arbStrobes_t       strobes
);
  logic [NUM_CH-1:0] lowestPend;

  // Isolate the lowest set bit: the highest priority pending channel.
  assign lowestPend = pendQ & (~pendQ + NUM_CH'(1));

  assign strobes.completeMask  = xferDone & grantQ;
  assign strobes.underflowMask = cntUnderflow & grantQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      grantQ <= '0;
    else if (|strobes.completeMask) grantQ <= '0;
    else if (grantQ == '0)          grantQ <= lowestPend;
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       chanEnable,
  input  logic [NUM_CH*SEL_W-1:0] srcSel,
  input  logic [NUM_CH-1:0]       swTrig,
  input  logic [NUM_CH-1:0]       periphReq,
  input  logic [NUM_CH-1:0]       xferDone,
  input  logic [NUM_CH-1:0]       cntUnderflow,
  output logic [NUM_CH-1:0]       grant,
  output logic                    busy
);
  logic [NUM_CH-1:0] pendQ;
  logic [NUM_CH-1:0] grantQ;
  arbStrobes_t       strobes;

  dmaArbPendPath u_pend (
    .clk        (clk),
    .rstN       (rstN),
    .chanEnable (chanEnable),
    .srcSel     (srcSel),
    .swTrig     (swTrig),
    .periphReq  (periphReq),
    .strobes    (strobes),
    .pendQ      (pendQ)
  );

  dmaArbGrantCtl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .pendQ        (pendQ),
    .xferDone     (xferDone),
    .cntUnderflow (cntUnderflow),
    .grantQ       (grantQ),
    .strobes      (strobes)
  );

  assign grant = grantQ;
  assign busy  = |grantQ;
endmodule

// File: rtl/dmaArbChecker.sv
module dmaArbChecker
  import dma_arb_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_CH-1:0]       chanEnable,
  input logic [NUM_CH*SEL_W-1:0] srcSel,
  input logic [NUM_CH-1:0]       xferDone,
  input logic [NUM_CH-1:0]       cntUnderflow,
  input logic [NUM_CH-1:0]       grant,
  input logic                    busy,
  input logic [NUM_CH-1:0]       pendQ
);
  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  assert_grant_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(|(xferDone & grant))) |=> $stable(grant));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|(xferDone & grant)) |=> (grant == '0 && !busy));

  assert_priority_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (|pendQ)) |=>
      ((|(grant & $past(pendQ))) && (((grant - NUM_CH'(1)) & $past(pendQ)) == '0)));

  assert_disabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy) |=> ((grant & ~$past(chanEnable, 2)) == '0));

  assert_ring_link_R7: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone[2] && grant[2] && chanEnable[0] && srcSel[1:0] == 2'd2) |=> pendQ[0]);

  assert_underflow_link_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cntUnderflow[UFLOW_SRC] && grant[UFLOW_SRC] && chanEnable[UFLOW_DST]
     && srcSel[UFLOW_DST*SEL_W +: SEL_W] == 2'd2) |=> pendQ[UFLOW_DST]);
endmodule

bind dma_req_arbiter dmaArbChecker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .chanEnable   (chanEnable),
  .srcSel       (srcSel),
  .xferDone     (xferDone),
  .cntUnderflow (cntUnderflow),
  .grant        (grant),
  .busy         (busy),
  .pendQ        (pendQ)
);

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  chanEnable = '0;
  logic [19:0] srcSel = '0;
  logic [9:0]  swTrig = '0;
  logic [9:0]  periphReq = '0;
  logic [9:0]  xferDone = '0;
  logic [9:0]  cntUnderflow = '0;
  logic [9:0]  grant;
  logic        busy;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // Reference state: pending flags, current grant index (-1 none), last peripheral level.
  bit [9:0] mPend = '0;
  int       mGnt = -1;
  bit [9:0] mPrev = '0;
  bit       mJustReleased = 0;
  string    tag = "R1";

  // Knobs for the stimulus of the running phase (percent rates).
  int swRate, perRate, doneRate, uflowRate, spurRate, enFlipRate;

  always #2 clk = ~clk;

  dma_req_arbiter u_dut (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .srcSel(srcSel),
    .swTrig(swTrig), .periphReq(periphReq), .xferDone(xferDone),
    .cntUnderflow(cntUnderflow), .grant(grant), .busy(busy)
  );

  function automatic bit linked(int src, int dst);
    case (src)
      0: return dst == 1;
      1: return dst == 2;
      2: return dst == 0 || dst == 3;
      3: return dst == 4;
      5: return dst == 6;
      6: return dst == 7;
      7: return dst == 5 || dst == 8;
      8: return dst == 9;
      default: return 0;
    endcase
  endfunction

  function automatic bit roll(int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic compare();
    logic [9:0] expG;
    string gTag;
    expG = (mGnt >= 0) ? (10'd1 << mGnt) : 10'd0;
    gTag = mJustReleased ? "R6" : tag;
    vectors++;
    if (grant !== expG) begin
      fails++;
      $display("FAIL %s grant: actual %b expected %b at %0t", gTag, grant, expG, $time);
    end
    vectors++;
    if (busy !== (mGnt >= 0)) begin
      fails++;
      $display("FAIL R10 busy: actual %b expected %b at %0t", busy, (mGnt >= 0), $time);
    end
  endtask

  // Choose this cycle's inputs, then advance the reference to the state after the next edge.
  task automatic stepCycle();
    int comp;
    bit uf0;
    bit [9:0] np;
    int ng;
    swTrig = '0; xferDone = '0; cntUnderflow = '0;
    for (int c = 0; c < 10; c++) begin
      if (roll(swRate)) swTrig[c] = 1'b1;
      if (roll(perRate)) periphReq[c] = ~periphReq[c];
      if (roll(enFlipRate)) chanEnable[c] = ~chanEnable[c];
      if (c != mGnt && roll(spurRate)) begin
        xferDone[c] = 1'b1;
        cntUnderflow[c] = roll(50);
      end
    end
    if (mGnt >= 0 && roll(doneRate)) begin
      xferDone[mGnt] = 1'b1;
      cntUnderflow[mGnt] = roll(uflowRate);
    end

    comp = (mGnt >= 0 && xferDone[mGnt]) ? mGnt : -1;
    uf0 = (comp == 0) && cntUnderflow[0];
    for (int c = 0; c < 10; c++) begin
      bit cas, ev;
      int s;
      cas = (comp >= 0 && linked(comp, c)) || (c == 5 && uf0);
      s = srcSel[2*c +: 2];
      case (s)
        0: ev = swTrig[c];
        1: ev = periphReq[c] && !mPrev[c];
        2: ev = cas;
        default: ev = 0;
      endcase
      np[c] = chanEnable[c] && (ev || (mPend[c] && comp != c));
    end
    ng = mGnt;
    if (comp >= 0) ng = -1;
    else if (mGnt < 0) begin
      for (int c = 9; c >= 0; c--) if (mPend[c]) ng = c;
    end
    mJustReleased = (comp >= 0);
    mPend = np;
    mGnt = ng;
    mPrev = periphReq;
  endtask

  task automatic runPhase(string t, int cycles);
    tag = t;
    for (int i = 0; i < cycles; i++) begin
      stepCycle();
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    #700000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    swRate = 0; perRate = 0; doneRate = 0; uflowRate = 0; spurRate = 0; enFlipRate = 0;
    // R1: outputs idle during and right after reset
    repeat (3) @(negedge clk);
    compare();
    rstN = 1'b1;
    @(negedge clk);
    compare();

    // R2: software triggers on every channel
    chanEnable = '1; srcSel = '0;
    swRate = 10; doneRate = 50;
    runPhase("R2", 400);

    // R2: peripheral rising edges
    srcSel = {10{2'd1}}; swRate = 30; perRate = 20;
    runPhase("R2", 400);

    // R7 and R8: channel 0 seeds, every other channel rides the cascade network
    srcSel = {10{2'd2}}; srcSel[1:0] = 2'd0;
    swRate = 5; perRate = 0; doneRate = 40; uflowRate = 30;
    runPhase("R7", 300);
    runPhase("R8", 300);

    // R7: ring 0-1-2 fully cascaded once seeded through a software pulse on 0
    srcSel[1:0] = 2'd0; swRate = 20;
    runPhase("R7", 20);
    srcSel[1:0] = 2'd2; swRate = 0;
    runPhase("R7", 100);

    // R3: enables toggling under mixed sources
    for (int c = 0; c < 10; c++) srcSel[2*c +: 2] = 2'(c % 4);
    swRate = 25; perRate = 25; doneRate = 40; uflowRate = 30; enFlipRate = 10;
    runPhase("R3", 600);

    // R9 and R5: dense requests with late dones and spurious engine pulses
    chanEnable = '1; enFlipRate = 0;
    srcSel = '0; srcSel[9:2] = {4{2'd2}};
    swRate = 40; doneRate = 15; spurRate = 20;
    runPhase("R9", 600);
    runPhase("R5", 400);

    // R4: heavy contention on all channels
    srcSel = '0; swRate = 30; doneRate = 30; spurRate = 0;
    runPhase("R4", 600);

    // R1: reset in the middle of traffic returns to idle
    rstN = 1'b0; swTrig = '0; xferDone = '0; cntUnderflow = '0;
    mPend = '0; mGnt = -1; mPrev = periphReq; mJustReleased = 0; tag = "R1";
    @(negedge clk);
    compare();
    rstN = 1'b1;
    swRate = 0; doneRate = 0;
    runPhase("R1", 2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule